// File: doc/BRIEF.md
# Multi-mode sequence counter

A synchronous counter that walks through one of six fixed code sequences, picked by a mode select. On each rising clock edge with the enable high, the 4-bit state moves one place forward or back in the chosen sequence. The up/down input sets the direction. The sequences are:

- a 3-bit binary count;
- a Gray-style 3-bit code;
- a rotating one-hot ring;
- a decimal digit count;
- a 2-bit pseudo-random cycle;
- a binary count that wraps early at a programmable limit.

A combinational terminal-count flag marks the last code of the active sequence in the current direction. Controllers use this flag to time loops, divide clocks or sequence control steps.

Every state bit is held in one register bank clocked by the same edge, so all outputs change together and no stage is clocked by another stage's output. The counter registers the mode it is working in. When the select moves to a different mode, the next clock loads that mode's first code whatever the enable is doing. A synchronous reset does the same for the mode selected at the time.

Top module: `seqctr_top`

## Requirements
- R1: Mode 0 (binary) counts 0..7 in state[2:0] with state[3]=0; up goes 7→0 and down goes 0→7.
- R2: Mode 1 (Gray-style) visits 000,010,110,100,101,111,011,001 in state[2:0] and then repeats, with state[3]=0; down walks that order backwards (000→001).
- R3: Mode 2 (ring) goes 0001→0010→0100→1000→0001 when counting up and goes the reverse way when counting down; any state that is not one-hot is replaced by 0001 on the next enabled clock.
- R4: Mode 3 (decimal) counts 0..9; up goes 9→0 and down goes 0→9; the state never exceeds 9.
- R5: Mode 4 (pseudo-random) cycles state[1:0] through 10,01,00,11 and repeats, with state[3:2]=0; down walks that order backwards.
- R6: Mode 5 (early wrap) counts up from 0 to the 4-bit limit input and then to 0 (with limit 12: ...,11,12,0); down goes 0→limit.
- R7: The tc output is 1 exactly when the state holds the last code of the active sequence in the current direction. Counting up, that is the final code of the order listed above (the limit in mode 5). Counting down, it is the first code (0000, or 0001 in ring mode, or 0010 in pseudo-random mode).
- R8: While en is 0 and the mode select is unchanged, the state holds.
- R9: When the mode select differs from the active mode, the next clock makes it active and loads its first code, whatever en is. Select codes 6 and 7 act as mode 0.
- R10: Reset is synchronous and active high. On a clock with rst=1, the state becomes the first code of the selected mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable |
| up | input | 1 | 1 counts forward, 0 counts backward |
| mode | input | 3 | Sequence select (0..5; 6 and 7 act as 0) |
| lim | input | 4 | Wrap limit for mode 5 |
| state | output | 4 | Current code |
| tc | output | 1 | Terminal count for the current direction |

## Verification
Every mode is run forward and backward for more than one full lap, starting from its first code. A forward pass and a backward pass over the same lap tell a correct reverse order apart from a reused forward order, and they also show whether tc tracks the direction. Mode 5 runs with a limit of 12, which separates early wrapping from a plain 4-bit wrap at 15. Held-enable stimulus and a change of mode while the enable is low show that holding and restarting are separate. Three enabled steps after selecting code 6 give 0011, which a ring sequence could not produce.

// File: rtl/seqctr_pkg.sv
package seqctr_pkg;

    localparam int ST_W   = 4;
    localparam int MODE_W = 3;
    localparam int GIX_W  = 3;
    localparam int PIX_W  = 2;

    typedef enum logic [MODE_W-1:0] {
        M_BIN  = 3'd0,
        M_GRAY = 3'd1,
        M_RING = 3'd2,
        M_BCD  = 3'd3,
        M_PRNG = 3'd4,
        M_WRAP = 3'd5
    } mode_e;

    typedef struct packed {
        mode_e           mode;
        logic [ST_W-1:0] state;
    } ctr_t;

    function automatic mode_e norm_mode(input logic [MODE_W-1:0] m);
        if (m > 3'd5) return M_BIN;
        return mode_e'(m);
    endfunction

    function automatic logic [ST_W-1:0] first_code(input mode_e m);
        case (m)
            M_RING:  return 4'b0001;
            M_PRNG:  return 4'b0010;
            default: return 4'b0000;
        endcase
    endfunction

    // Position of a code within the Gray-style walk
    function automatic logic [GIX_W-1:0] gray_pos(input logic [GIX_W-1:0] g);
        case (g)
            3'b000:  return 3'd0;
            3'b010:  return 3'd1;
            3'b110:  return 3'd2;
            3'b100:  return 3'd3;
            3'b101:  return 3'd4;
            3'b111:  return 3'd5;
            3'b011:  return 3'd6;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic [GIX_W-1:0] gray_at(input logic [GIX_W-1:0] p);
        case (p)
            3'd0:    return 3'b000;
            3'd1:    return 3'b010;
            3'd2:    return 3'b110;
            3'd3:    return 3'b100;
            3'd4:    return 3'b101;
            3'd5:    return 3'b111;
            3'd6:    return 3'b011;
            default: return 3'b001;
        endcase
    endfunction

    function automatic logic [PIX_W-1:0] prng_pos(input logic [PIX_W-1:0] c);
        case (c)
            2'b10:   return 2'd0;
            2'b01:   return 2'd1;
            2'b00:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [PIX_W-1:0] prng_at(input logic [PIX_W-1:0] p);
        case (p)
            2'd0:    return 2'b10;
            2'd1:    return 2'b01;
            2'd2:    return 2'b00;
            default: return 2'b11;
        endcase
    endfunction

endpackage

// File: rtl/seqctr_next.sv
module seqctr_next
    import seqctr_pkg::*;
(
    input  mode_e           mode,
    input  logic            up,
    input  logic [ST_W-1:0] cur,
    input  logic [ST_W-1:0] lim,
    output logic [ST_W-1:0] nxt
);

    localparam logic [ST_W-1:0] BCD_TOP = 4'd9;

    logic                   a, b, c;
    logic [GIX_W-1:0]       gpos, gnew;
    logic [PIX_W-1:0]       ppos, pnew;
    logic                   ring_ok;

    assign a = cur[0];
    assign b = cur[1];
    assign c = cur[2];

    always_comb begin
        gpos    = gray_pos(cur[GIX_W-1:0]);
        gnew    = up ? gpos + 3'd1 : gpos - 3'd1;
        ppos    = prng_pos(cur[PIX_W-1:0]);
        pnew    = up ? ppos + 2'd1 : ppos - 2'd1;
        ring_ok = (cur != '0) && ((cur & (cur - 4'd1)) == '0);
    end

    always_comb begin
        nxt = cur;
        case (mode)
            M_BIN: begin
                if (up) nxt = {1'b0, c ^ (a & b), b ^ a, ~a};
                else    nxt = {1'b0, c ^ (~a & ~b), b ^ ~a, ~a};
            end
            M_GRAY: nxt = {1'b0, gray_at(gnew)};
            M_RING: begin
                if (!ring_ok)  nxt = 4'b0001;
                else if (up)   nxt = {cur[ST_W-2:0], cur[ST_W-1]};
                else           nxt = {cur[0], cur[ST_W-1:1]};
            end
            M_BCD: begin
                if (up) nxt = (cur >= BCD_TOP) ? '0 : cur + 4'd1;
                else    nxt = (cur == '0 || cur > BCD_TOP) ? BCD_TOP : cur - 4'd1;
            end
            M_PRNG: nxt = {2'b00, prng_at(pnew)};
            M_WRAP: begin
                if (up)             nxt = (cur >= lim) ? '0 : cur + 4'd1;
                else if (cur == '0) nxt = lim;
                else                nxt = (cur > lim) ? lim : cur - 4'd1;
            end
            default: nxt = '0;
        endcase
    end

endmodule

// File: rtl/seqctr_term.sv
module seqctr_term
    import seqctr_pkg::*;
(
    input  mode_e           mode,
    input  logic            up,
    input  logic [ST_W-1:0] cur,
    input  logic [ST_W-1:0] lim,
    output logic            tc
);

    logic [ST_W-1:0] end_up;

    always_comb begin
        case (mode)
            M_BIN:   end_up = 4'b0111;
            M_GRAY:  end_up = 4'b0001;
            M_RING:  end_up = 4'b1000;
            M_BCD:   end_up = 4'b1001;
            M_PRNG:  end_up = 4'b0011;
            M_WRAP:  end_up = lim;
            default: end_up = 4'b0111;
        endcase
        tc = up ? (cur == end_up) : (cur == first_code(mode));
    end

endmodule

// File: rtl/seqctr_top.sv
module seqctr_top
    import seqctr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                up,
    input  logic [MODE_W-1:0]   mode,
    input  logic [ST_W-1:0]     lim,
    output logic [ST_W-1:0]     state,
    output logic                tc
);

    ctr_t            r_d, r_q;
    mode_e           sel_mode;
    logic [ST_W-1:0] step_code;

    assign sel_mode = norm_mode(mode);

    seqctr_next u_next (
        .mode (r_q.mode),
        .up   (up),
        .cur  (r_q.state),
        .lim  (lim),
        .nxt  (step_code)
    );

    seqctr_term u_term (
        .mode (r_q.mode),
        .up   (up),
        .cur  (r_q.state),
        .lim  (lim),
        .tc   (tc)
    );

    always_comb begin
        r_d = r_q;
        if (rst || sel_mode != r_q.mode) begin
            r_d.mode  = sel_mode;
            r_d.state = first_code(sel_mode);
        end else if (en) begin
            r_d.state = step_code;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign state = r_q.state;

    AST_RING_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (r_q.mode == M_RING) |-> $onehot(r_q.state)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!en && sel_mode == r_q.mode) |=> $stable(r_q.state)); // R8

    AST_BCD_RANGE: assert property (@(posedge clk) disable iff (rst)
        (r_q.mode == M_BCD) |-> (r_q.state <= 4'd9)); // R4

    AST_NARROW_TOP: assert property (@(posedge clk) disable iff (rst)
        (r_q.mode == M_BIN || r_q.mode == M_GRAY) |-> !r_q.state[3]); // R1

    AST_PRNG_UPPER: assert property (@(posedge clk) disable iff (rst)
        (r_q.mode == M_PRNG) |-> (r_q.state[3:2] == 2'b00)); // R5

    AST_WRAP_BOUND: assert property (@(posedge clk) disable iff (rst)
        (r_q.mode == M_WRAP && sel_mode == M_WRAP && r_q.state <= lim)
        |=> (r_q.state <= $past(lim))); // R6

endmodule

// File: tb/seqctr_top_tb.sv
module seqctr_top_tb;

    logic       clk = 1'b0;
    logic       rst, en, up;
    logic [2:0] mode;
    logic [3:0] lim;
    logic [3:0] state;
    logic       tc;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    seqctr_top u_dut (
        .clk(clk), .rst(rst), .en(en), .up(up),
        .mode(mode), .lim(lim), .state(state), .tc(tc)
    );

    always #5 clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    function automatic int seq_len(input int m);
        case (m)
            1: return 8;
            2: return 4;
            3: return 10;
            4: return 4;
            default: return 8;
        endcase
    endfunction

    function automatic logic [3:0] seq_code(input int m, input int i);
        case (m)
            1: case (i)
                   0: return 4'b0000; 1: return 4'b0010; 2: return 4'b0110; 3: return 4'b0100;
                   4: return 4'b0101; 5: return 4'b0111; 6: return 4'b0011; default: return 4'b0001;
               endcase
            2: return 4'(1 << i);
            4: case (i)
                   0: return 4'b0010; 1: return 4'b0001; 2: return 4'b0000; default: return 4'b0011;
               endcase
            default: return 4'(i);
        endcase
    endfunction

    task automatic do_reset(input int m);
        rst = 1'b1; en = 1'b0; mode = 3'(m);
        tick();
        rst = 1'b0;
    endtask

    // Walk a mode for more than one lap in the given direction
    task automatic run_seq(input int m, input bit dir, input string req);
        int len = seq_len(m);
        do_reset(m);
        up = dir;
        check("R10", state, seq_code(m, 0));
        en = 1'b1;
        for (int k = 0; k <= len + 2; k++) begin
            int idx = dir ? (k % len) : ((len - (k % len)) % len);
            bit exp_tc = dir ? (idx == len - 1) : (idx == 0);
            #1;
            check(req, state, seq_code(m, idx));
            check({req, " R7 tc"}, {3'b0, tc}, {3'b0, exp_tc});
            tick();
        end
        en = 1'b0;
    endtask

    task automatic run_wrap(input bit dir);
        lim = 4'd12;
        do_reset(5);
        up = dir;
        en = 1'b1;
        for (int k = 0; k <= 15; k++) begin
            int v = dir ? (k % 13) : ((13 - (k % 13)) % 13);
            bit exp_tc = dir ? (v == 12) : (v == 0);
            #1;
            check("R6", state, 4'(v));
            check("R6 R7 tc", {3'b0, tc}, {3'b0, exp_tc});
            tick();
        end
        en = 1'b0;
    endtask

    task automatic test_hold();
        do_reset(3);
        up = 1'b1; en = 1'b1;
        for (int k = 0; k < 5; k++) tick();
        en = 1'b0;
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R8 hold", state, 4'd5);
        end
    endtask

    task automatic test_mode_change();
        do_reset(0);
        up = 1'b1; en = 1'b1;
        for (int k = 0; k < 3; k++) tick();
        check("R9 pre", state, 4'd3);
        en = 1'b0; mode = 3'd2;
        tick();
        check("R9 to ring", state, 4'b0001);
        mode = 3'd6;
        tick();
        check("R9 code6 restart", state, 4'b0000);
        en = 1'b1;
        for (int k = 0; k < 3; k++) tick();
        check("R9 code6 binary", state, 4'd3);
        check("R1 via code6", {3'b0, tc}, 4'd0);
        en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; en = 1'b0; up = 1'b1; mode = 3'd0; lim = 4'd12;
        tick(); tick();
        check("R10 reset", state, 4'd0);
        rst = 1'b0;
        run_seq(0, 1'b1, "R1 up");
        run_seq(0, 1'b0, "R1 down");
        run_seq(1, 1'b1, "R2 up");
        run_seq(1, 1'b0, "R2 down");
        run_seq(2, 1'b1, "R3 up");
        run_seq(2, 1'b0, "R3 down");
        run_seq(3, 1'b1, "R4 up");
        run_seq(3, 1'b0, "R4 down");
        run_seq(4, 1'b1, "R5 up");
        run_seq(4, 1'b0, "R5 down");
        run_wrap(1'b1);
        run_wrap(1'b0);
        test_hold();
        test_mode_change();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule